// File: doc/BRIEF.md
# Leading and Trailing Zero Counter

This unit counts a run of zero bits in a 64-bit operand. A direction select picks where the run starts. When it is low, the run starts at the most significant bit and the unit counts leading zeros. When it is high, the run starts at bit 0 and the unit counts trailing zeros. A width select narrows the operation to the low 32-bit word. In that mode the upper half of the operand has no effect, and the count reaches at most 32.

The operand and both selects are sampled on a rising clock edge. The count appears on a 64-bit, zero-extended result one cycle later and then holds until the next edge. The unit accepts a new operand on every cycle, so it has no handshake. An execution pipeline can place it directly in a single-cycle slot.

Top module: `zero_count_unit`

## Requirements
- R1: The result is a registered value that a synchronous active-high reset clears to 0. While reset is high, the result stays 0.
- R2: The result becomes valid on the first rising edge after the inputs are applied. It keeps that value until the next edge, whatever the inputs do in between.
- R3: With `count_trailing` = 0 and `word_mode` = 0, the result is the number of consecutive zero bits running from bit 63 towards bit 0.
- R4: With `count_trailing` = 1 and `word_mode` = 0, the result is the number of consecutive zero bits running from bit 0 towards bit 63.
- R5: With `count_trailing` = 0 and `word_mode` = 1, the result is the number of consecutive zero bits running from bit 31 towards bit 0.
- R6: With `count_trailing` = 1 and `word_mode` = 1, the result is the number of consecutive zero bits running from bit 0 towards bit 31.
- R7: An operand that is zero over the selected width gives 64 (0x40) in full mode and 32 (0x20) in word mode, in both directions.
- R8: In word mode, bits 63:32 of the operand have no effect on the result. When bits 31:0 are all zero, the result is 32 whatever the upper bits hold.
- R9: Result bits 63:7 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| operand | input | 64 | Value whose zero run is counted |
| count_trailing | input | 1 | 0: count from the top bit of the selected width; 1: count from bit 0 |
| word_mode | input | 1 | 0: all 64 bits; 1: only bits 31:0 |
| zero_count | output | 64 | Registered count, zero-extended |

## Verification
Each count is due exactly one rising edge after its operand and selects are applied. The bench therefore drives the inputs on a falling edge and compares the result on the next falling edge, half a period after the capturing edge. To prove that the result comes from a register, one check changes the inputs and then reads the result again before the next rising edge; it must still show the previous count. A reset check asserts reset over a cycle that has a nonzero count and expects 0 after that one edge.

// File: rtl/zcu_pkg.sv
package zcu_pkg;
  localparam int DATA_W = 64;
  localparam int WORD_W = 32;
  localparam int CNT_W  = $clog2(DATA_W) + 1;
endpackage

// File: rtl/zcu_align.sv
module zcu_align #(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32
) (
  input  logic [DATA_W-1:0] operand,
  input  logic              count_trailing,
  input  logic              word_mode,
  output logic [DATA_W-1:0] aligned
);
  localparam int PAD_W = DATA_W - WORD_W - 1;

  logic [DATA_W-1:0] reversed;
  logic [DATA_W-1:0] full_src;
  logic [WORD_W-1:0] word_src;

  // Bit reversal turns a trailing count into a leading count.
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign reversed[i] = operand[DATA_W-1-i];
  end

  always_comb begin
    full_src = count_trailing ? reversed : operand;
    word_src = count_trailing ? reversed[DATA_W-1 -: WORD_W] : operand[WORD_W-1:0];
    // In word mode a guard one sits just below the word, so the count stops at WORD_W.
    if (word_mode)
      aligned = {word_src, 1'b1, {PAD_W{1'b0}}};
    else
      aligned = full_src;
  end
endmodule

// File: rtl/zcu_lead.sv
module zcu_lead #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 7
) (
  input  logic [DATA_W-1:0] vec,
  output logic [CNT_W-1:0]  count
);
  always_comb begin
    count = CNT_W'(DATA_W);
    for (int i = 0; i < DATA_W; i++) begin
      if (vec[i]) count = CNT_W'(DATA_W - 1 - i);
    end
  end
endmodule

// File: rtl/zero_count_unit.sv
module zero_count_unit
  import zcu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] operand,
  input  logic              count_trailing,
  input  logic              word_mode,
  output logic [DATA_W-1:0] zero_count
);
  logic [DATA_W-1:0] aligned;
  logic [CNT_W-1:0]  count_d;
  logic [CNT_W-1:0]  count_q;

  zcu_align #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_align (
    .operand        (operand),
    .count_trailing (count_trailing),
    .word_mode      (word_mode),
    .aligned        (aligned)
  );

  zcu_lead #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_lead (
    .vec   (aligned),
    .count (count_d)
  );

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= count_d;
  end

  assign zero_count = {{(DATA_W-CNT_W){1'b0}}, count_q};
endmodule

// File: rtl/zcu_checker.sv
module zcu_checker (
  input logic        clk,
  input logic        rst,
  input logic [63:0] operand,
  input logic        count_trailing,
  input logic        word_mode,
  input logic [63:0] zero_count
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> zero_count == 64'd0); // R1
  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    zero_count[63:7] == '0); // R9
  AST_FULL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!word_mode && operand == 64'd0) |=> zero_count == 64'd64); // R7
  AST_WORD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (word_mode && operand[31:0] == 32'd0) |=> zero_count == 64'd32); // R8
  AST_TOP_SET: assert property (@(posedge clk) disable iff (rst)
    (!count_trailing && !word_mode && operand[63]) |=> zero_count == 64'd0); // R3
  AST_BIT0_SET: assert property (@(posedge clk) disable iff (rst)
    (count_trailing && operand[0]) |=> zero_count == 64'd0); // R4
  AST_WORD_TOP_SET: assert property (@(posedge clk) disable iff (rst)
    (!count_trailing && word_mode && operand[31]) |=> zero_count == 64'd0); // R5
  AST_WORD_LIMIT: assert property (@(posedge clk) disable iff (rst)
    word_mode |=> zero_count <= 64'd32); // R6
endmodule

bind zero_count_unit zcu_checker u_zcu_checker (
  .clk            (clk),
  .rst            (rst),
  .operand        (operand),
  .count_trailing (count_trailing),
  .word_mode      (word_mode),
  .zero_count     (zero_count)
);

// File: tb/tb_zero_count_unit.sv
`timescale 1ns/1ps
module tb_zero_count_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] operand = '0;
  logic        count_trailing = 1'b0;
  logic        word_mode = 1'b0;
  logic [63:0] zero_count;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk = ~clk; // 125 MHz

  zero_count_unit dut (
    .clk            (clk),
    .rst            (rst),
    .operand        (operand),
    .count_trailing (count_trailing),
    .word_mode      (word_mode),
    .zero_count     (zero_count)
  );

  localparam int NT = 12;
  // Entry tags: 0-2 R3, 3-4 R4, 5-6 R8, 7 R5, 8 R6, 9-10 R7, 11 R4
  localparam logic [63:0] T_OP [NT] = '{
    64'h8000_0000_0000_0000, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001,
    64'h0000_0000_0000_0001, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_0000_0000,
    64'hFFFF_FFFF_0000_0000, 64'h1234_5678_0001_0000, 64'h1234_5678_0001_0000,
    64'h0, 64'h0, 64'h0000_0000_0000_0100};
  localparam logic [NT-1:0] T_TR = 12'b1001_0101_1000; // bit k = entry k
  localparam logic [NT-1:0] T_WD = 12'b0101_1110_0000;
  localparam int T_EXP [NT] = '{0, 31, 63, 0, 63, 32, 32, 15, 16, 64, 32, 8};

  task automatic check(input logic [63:0] exp, input string tag);
    n_run++;
    if (zero_count !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d (0x%h) expected %0d", tag, zero_count, zero_count, exp);
    end
  endtask

  task automatic apply(input logic [63:0] op, input logic tr, input logic wd);
    @(negedge clk);
    operand = op; count_trailing = tr; word_mode = wd;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] bg;
    logic [31:0] lo;
    repeat (3) @(negedge clk);
    check(64'd0, "R1 reset state");
    rst = 1'b0;

    for (int k = 0; k < NT; k++) begin
      apply(T_OP[k], T_TR[k], T_WD[k]);
      check(64'(T_EXP[k]), $sformatf("table entry %0d", k));
    end

    for (int p = 0; p < 64; p++) begin
      bg = {$urandom, $urandom};
      apply((bg | 64'h8000_0000_0000_0000) >> p, 1'b0, 1'b0);
      check(64'(p), "R3 leading walk");
      bg = {$urandom, $urandom};
      apply((bg | 64'h1) << p, 1'b1, 1'b0);
      check(64'(p), "R4 trailing walk");
    end

    for (int p = 0; p <= 32; p++) begin
      lo = $urandom;
      lo = (lo | 32'h8000_0000) >> p;
      apply({32'($urandom), lo}, 1'b0, 1'b1);
      check(64'(p), "R5 word leading walk");
      lo = $urandom;
      lo = (lo | 32'h1) << p;
      apply({32'($urandom), lo}, 1'b1, 1'b1);
      check(64'(p), "R6 word trailing walk");
    end

    // R8: same low word, different upper words
    apply(64'h0000_0000_0000_0400, 1'b1, 1'b1);
    check(64'd10, "R8 upper clear");
    apply(64'hFFFF_FFFF_0000_0400, 1'b1, 1'b1);
    check(64'd10, "R8 upper set");

    // R7: all-zero operand in every mode
    apply(64'h0, 1'b0, 1'b0); check(64'd64, "R7 zero full leading");
    apply(64'h0, 1'b1, 1'b1); check(64'd32, "R7 zero word trailing");

    // R2: the result holds between edges
    apply(64'h0000_0000_0000_0010, 1'b1, 1'b0);
    operand = 64'h8000_0000_0000_0000; count_trailing = 1'b0;
    #1;
    check(64'd4, "R2 held before edge");
    @(negedge clk);
    check(64'd0, "R2 new value after edge");

    // R1 and R9: reset over a nonzero count
    apply(64'h0000_0000_0000_0001, 1'b0, 1'b0);
    check(64'd63, "R9 count in low bits");
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check(64'd0, "R1 reset clears");
    rst = 1'b0;
    @(negedge clk);
    check(64'd63, "R1 resume after reset");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule